// File: doc/BRIEF.md
# In-Order Retirement Buffer with Operand Search

This block tracks every instruction that a single-issue, in-order front end sends into execution units that may finish in any order. Each issued instruction takes the next free slot of a circular store and receives that slot number as its tag. Execution units return results tagged with that number in whatever order they finish. The oldest slot drains to the architectural register file as soon as its result is present, one slot per cycle. Architectural state therefore changes in program order, and a faulting instruction can be reported precisely.

Source operands for a new instruction are resolved through a search port. It looks at every occupied slot and picks the youngest one that writes the requested register. It then reports that slot's result, or reports that the result is still pending and names the slot to wait on. When no slot writes the register, the search reports a miss and the caller reads the register file. When a branch resolves as mispredicted, the caller names the branch's tag. Every slot younger than the branch is discarded, and allocation resumes right after the branch.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: alloc_ready_o is 1, alloc_tag_o is 0, ret_valid_o and ret_exc_o are 0, and every search reports lk_hit_o = 0.
- R2: An accepted allocation takes the tag shown on alloc_tag_o. Successive allocations receive consecutive tags that wrap modulo the depth (16), and a new slot starts with no result.
- R3: With 16 slots occupied, alloc_ready_o is 0 and a request on alloc_valid_i is dropped: no slot is created and alloc_tag_o keeps its value.
- R4: A writeback on wb_tag_i to an occupied slot stores wb_data_i and wb_exc_i and marks the result present, in any order relative to other slots.
- R5: Only the oldest slot retires, and only once its result is present. At most one slot retires per cycle. A retiring slot without a fault drives ret_valid_o = 1 with its destination and result, so retirements appear in allocation order.
- R6: A retiring slot whose writeback set the fault flag drives ret_exc_o = 1 for exactly one cycle instead of ret_valid_o, and the slot is removed.
- R7: The search returns the youngest occupied slot whose destination equals lk_reg_i, including across the wrap point. If its result is present, lk_hit_o = 1, lk_ready_o = 1, lk_tag_o is that slot and lk_data_o is its result.
- R8: If the youngest matching slot has no result yet, the search reports lk_hit_o = 1, lk_ready_o = 0 and that slot's tag, even when an older matching slot holds a result.
- R9: With no occupied slot writing lk_reg_i, lk_hit_o = 0 and lk_ready_o = 0.
- R10: flush_i with flush_tag_i naming an occupied branch slot discards every younger slot. The next allocation tag becomes flush_tag_i + 1, and searches no longer see the discarded slots.
- R11: flush_i is ignored when flush_tag_i names a free slot or a slot allocated with alloc_branch_i = 0.
- R12: A writeback to a free or discarded slot is ignored; a later allocation of that tag starts with no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Request a slot for an issued instruction |
| alloc_dst_i | input | REG_W | Destination register of the issued instruction |
| alloc_branch_i | input | 1 | Issued instruction is a branch that may be flushed against |
| alloc_ready_o | output | 1 | A free slot exists |
| alloc_tag_o | output | TAG_W | Tag given to the next allocation |
| wb_valid_i | input | 1 | Result writeback strobe |
| wb_tag_i | input | TAG_W | Slot addressed by the writeback |
| wb_data_i | input | DATA_W | Result value |
| wb_exc_i | input | 1 | Instruction faulted |
| ret_valid_o | output | 1 | Register file write from the oldest slot |
| ret_reg_o | output | REG_W | Register file write address |
| ret_data_o | output | DATA_W | Register file write data |
| ret_tag_o | output | TAG_W | Tag of the slot at the head |
| ret_exc_o | output | 1 | Oldest slot retires with a fault (write suppressed) |
| flush_i | input | 1 | Mispredicted branch recovery strobe |
| flush_tag_i | input | TAG_W | Tag of the mispredicted branch |
| lk_reg_i | input | REG_W | Register to search for |
| lk_hit_o | output | 1 | An occupied slot writes lk_reg_i |
| lk_ready_o | output | 1 | The youngest such slot holds its result |
| lk_tag_o | output | TAG_W | Tag of the youngest matching slot |
| lk_data_o | output | DATA_W | Result of the youngest matching slot |

## Verification
A wrong tail pointer shows on alloc_tag_o one cycle after the allocate or flush that moved it. A wrong head pointer or a lost result flag shows as retirements that stop, skip a slot or arrive out of order on the retire port, starting in the cycle after the writeback. A slot that should have been discarded, or a bad youngest-first priority, shows at once on the search port as a wrong tag or a wrong ready flag. The checks read that port after every flush and every writeback.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int unsigned ROB_DEPTH_DEF = 16;
  localparam int unsigned REG_W_DEF     = 5;
  localparam int unsigned DATA_W_DEF    = 32;

  typedef enum logic [1:0] {
    LK_MISS  = 2'b00,
    LK_PEND  = 2'b01,
    LK_READY = 2'b11
  } lk_state_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned TAG_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = TAG_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             retire_i,
  input  logic             flush_i,
  input  logic [TAG_W-1:0] flush_tag_i,
  output logic [TAG_W-1:0] head_o,
  output logic [TAG_W-1:0] tail_o,
  output logic             full_o
);
  logic [TAG_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic [TAG_W-1:0] flush_age;
  logic [CNT_W-1:0] keep_cnt;

  // slots kept by a flush: head .. branch inclusive
  assign flush_age = flush_tag_i - head_q;
  assign keep_cnt  = CNT_W'(flush_age) + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (retire_i) head_q <= head_q + TAG_W'(1);
      if (flush_i) begin
        tail_q  <= flush_tag_i + TAG_W'(1);
        count_q <= keep_cnt - CNT_W'(retire_i);
      end else begin
        tail_q  <= tail_q + TAG_W'(alloc_i);
        count_q <= count_q + CNT_W'(alloc_i) - CNT_W'(retire_i);
      end
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign full_o = (count_q == CNT_W'(DEPTH));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  p_full_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !alloc_i);
  p_retire_nonempty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i |-> (count_q != '0));
  p_head_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i |=> (head_q == $past(head_q) + TAG_W'(1)));
  p_flush_tail_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (tail_q == $past(flush_tag_i) + TAG_W'(1)));
endmodule

// File: rtl/rob_lookup.sv
module rob_lookup #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned TAG_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]  valid_i,
  input  logic [DEPTH-1:0]  done_i,
  input  logic [REG_W-1:0]  dst_i  [DEPTH],
  input  logic [DATA_W-1:0] data_i [DEPTH],
  input  logic [TAG_W-1:0]  head_i,
  input  logic [REG_W-1:0]  reg_i,
  output rob_pkg::lk_state_e state_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DEPTH-1:0] match;
  logic             found;
  logic [TAG_W-1:0] sel;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (dst_i[g] == reg_i);
  end

  // walk oldest -> youngest; last hit wins, so the youngest producer is kept
  always_comb begin
    found = 1'b0;
    sel   = head_i;
    for (int unsigned k = 0; k < DEPTH; k++) begin
      if (match[head_i + TAG_W'(k)]) begin
        found = 1'b1;
        sel   = head_i + TAG_W'(k);
      end
    end
  end

  always_comb begin
    if (!found)           state_o = rob_pkg::LK_MISS;
    else if (done_i[sel]) state_o = rob_pkg::LK_READY;
    else                  state_o = rob_pkg::LK_PEND;
  end

  assign tag_o  = sel;
  assign data_o = data_i[sel];
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH  = ROB_DEPTH_DEF,
  parameter int unsigned REG_W  = REG_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  localparam int unsigned TAG_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic [REG_W-1:0]  alloc_dst_i,
  input  logic              alloc_branch_i,
  output logic              alloc_ready_o,
  output logic [TAG_W-1:0]  alloc_tag_o,
  input  logic              wb_valid_i,
  input  logic [TAG_W-1:0]  wb_tag_i,
  input  logic [DATA_W-1:0] wb_data_i,
  input  logic              wb_exc_i,
  output logic              ret_valid_o,
  output logic [REG_W-1:0]  ret_reg_o,
  output logic [DATA_W-1:0] ret_data_o,
  output logic [TAG_W-1:0]  ret_tag_o,
  output logic              ret_exc_o,
  input  logic              flush_i,
  input  logic [TAG_W-1:0]  flush_tag_i,
  input  logic [REG_W-1:0]  lk_reg_i,
  output logic              lk_hit_o,
  output logic              lk_ready_o,
  output logic [TAG_W-1:0]  lk_tag_o,
  output logic [DATA_W-1:0] lk_data_o
);
  logic [DEPTH-1:0]  ent_valid, ent_done, ent_exc, ent_branch;
  logic [REG_W-1:0]  ent_dst  [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];

  logic [TAG_W-1:0] head, tail, flush_age;
  logic             full, head_ret, alloc_fire, wb_fire, flush_fire;
  lk_state_e        lk_state;

  assign flush_fire = flush_i && ent_valid[flush_tag_i] && ent_branch[flush_tag_i];
  assign alloc_fire = alloc_valid_i && !full && !flush_fire;
  assign wb_fire    = wb_valid_i && ent_valid[wb_tag_i];
  assign head_ret   = ent_valid[head] && ent_done[head];
  assign flush_age  = flush_tag_i - head;

  rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_i     (alloc_fire),
    .retire_i    (head_ret),
    .flush_i     (flush_fire),
    .flush_tag_i (flush_tag_i),
    .head_o      (head),
    .tail_o      (tail),
    .full_o      (full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_valid  <= '0;
      ent_done   <= '0;
      ent_exc    <= '0;
      ent_branch <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_fire && (tail == TAG_W'(i))) begin
          ent_valid[i]  <= 1'b1;
          ent_done[i]   <= 1'b0;
          ent_exc[i]    <= 1'b0;
          ent_branch[i] <= alloc_branch_i;
        end else if (flush_fire && ((TAG_W'(i) - head) > flush_age)) begin
          ent_valid[i] <= 1'b0;
        end else if (head_ret && (head == TAG_W'(i))) begin
          ent_valid[i] <= 1'b0;
        end else if (wb_fire && (wb_tag_i == TAG_W'(i))) begin
          ent_done[i] <= 1'b1;
          ent_exc[i]  <= wb_exc_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc_fire && (tail == TAG_W'(i))) ent_dst[i] <= alloc_dst_i;
      if (wb_fire && (wb_tag_i == TAG_W'(i))) ent_data[i] <= wb_data_i;
    end
  end

  rob_lookup #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_lookup (
    .valid_i (ent_valid),
    .done_i  (ent_done),
    .dst_i   (ent_dst),
    .data_i  (ent_data),
    .head_i  (head),
    .reg_i   (lk_reg_i),
    .state_o (lk_state),
    .tag_o   (lk_tag_o),
    .data_o  (lk_data_o)
  );

  assign lk_hit_o   = (lk_state != LK_MISS);
  assign lk_ready_o = (lk_state == LK_READY);

  assign alloc_ready_o = !full;
  assign alloc_tag_o   = tail;
  assign ret_valid_o   = head_ret && !ent_exc[head];
  assign ret_exc_o     = head_ret && ent_exc[head];
  assign ret_reg_o     = ent_dst[head];
  assign ret_data_o    = ent_data[head];
  assign ret_tag_o     = head;

  p_full_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alloc_ready_o && !flush_fire) |=> (alloc_tag_o == $past(alloc_tag_o)));
  p_wb_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_i && !ent_valid[wb_tag_i] && !(alloc_fire && (tail == wb_tag_i)))
    |=> (ent_done[$past(wb_tag_i)] == $past(ent_done[wb_tag_i])));
  p_lk_producer_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (ent_valid[lk_tag_o] && (ent_dst[lk_tag_o] == lk_reg_i)));
  p_flush_kills_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_fire && ((flush_tag_i + TAG_W'(1)) != head))
    |=> !ent_valid[$past(flush_tag_i) + TAG_W'(1)]);
  p_exc_one_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_exc_o |=> (ret_tag_o != $past(ret_tag_o)));
endmodule

// File: tb/rob_core_bench.sv
module rob_core_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        alloc_valid_i = 1'b0;
  logic [4:0]  alloc_dst_i = '0;
  logic        alloc_branch_i = 1'b0;
  logic        alloc_ready_o;
  logic [3:0]  alloc_tag_o;
  logic        wb_valid_i = 1'b0;
  logic [3:0]  wb_tag_i = '0;
  logic [31:0] wb_data_i = '0;
  logic        wb_exc_i = 1'b0;
  logic        ret_valid_o;
  logic [4:0]  ret_reg_o;
  logic [31:0] ret_data_o;
  logic [3:0]  ret_tag_o;
  logic        ret_exc_o;
  logic        flush_i = 1'b0;
  logic [3:0]  flush_tag_i = '0;
  logic [4:0]  lk_reg_i = '0;
  logic        lk_hit_o, lk_ready_o;
  logic [3:0]  lk_tag_o;
  logic [31:0] lk_data_o;

  int n_chk = 0;
  int n_bad = 0;
  int n_log = 0;
  int n_exc = 0;
  int cyc = 0;
  logic [4:0]  log_reg  [64];
  logic [31:0] log_data [64];
  int          log_cyc  [64];

  always #10 clk = ~clk;

  rob_core u_rob_core (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_valid_i(alloc_valid_i), .alloc_dst_i(alloc_dst_i),
    .alloc_branch_i(alloc_branch_i), .alloc_ready_o(alloc_ready_o),
    .alloc_tag_o(alloc_tag_o),
    .wb_valid_i(wb_valid_i), .wb_tag_i(wb_tag_i), .wb_data_i(wb_data_i),
    .wb_exc_i(wb_exc_i),
    .ret_valid_o(ret_valid_o), .ret_reg_o(ret_reg_o), .ret_data_o(ret_data_o),
    .ret_tag_o(ret_tag_o), .ret_exc_o(ret_exc_o),
    .flush_i(flush_i), .flush_tag_i(flush_tag_i),
    .lk_reg_i(lk_reg_i), .lk_hit_o(lk_hit_o), .lk_ready_o(lk_ready_o),
    .lk_tag_o(lk_tag_o), .lk_data_o(lk_data_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (ret_valid_o && n_log < 64) begin
        log_reg[n_log]  = ret_reg_o;
        log_data[n_log] = ret_data_o;
        log_cyc[n_log]  = cyc;
        n_log++;
      end
      if (ret_exc_o) n_exc++;
    end
  end

  // row: wb, wb_tag, wb_data, lk_reg, exp_hit, exp_ready, exp_tag, exp_data
  localparam int NROW = 6;
  localparam logic [79:0] VEC [NROW] = '{
    {1'b1, 4'd2, 32'h0000_00A2, 5'd3, 1'b1, 1'b0, 4'd4, 32'h0},
    {1'b0, 4'd0, 32'h0,         5'd5, 1'b1, 1'b0, 4'd1, 32'h0},
    {1'b0, 4'd0, 32'h0,         5'd9, 1'b0, 1'b0, 4'd0, 32'h0},
    {1'b1, 4'd4, 32'h0000_00C4, 5'd3, 1'b1, 1'b1, 4'd4, 32'h0000_00C4},
    {1'b1, 4'd1, 32'h0000_00B1, 5'd5, 1'b1, 1'b1, 4'd1, 32'h0000_00B1},
    {1'b0, 4'd0, 32'h0,         5'd7, 1'b1, 1'b0, 4'd3, 32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_alloc(input logic [4:0] dst, input logic br, output logic [3:0] tag);
    alloc_valid_i = 1'b1; alloc_dst_i = dst; alloc_branch_i = br;
    #1 tag = alloc_tag_o;
    tick();
    alloc_valid_i = 1'b0; alloc_branch_i = 1'b0;
  endtask

  task automatic do_wb(input logic [3:0] tag, input logic [31:0] data, input logic exc);
    wb_valid_i = 1'b1; wb_tag_i = tag; wb_data_i = data; wb_exc_i = exc;
    tick();
    wb_valid_i = 1'b0; wb_exc_i = 1'b0;
  endtask

  task automatic do_flush(input logic [3:0] tag);
    flush_i = 1'b1; flush_tag_i = tag;
    tick();
    flush_i = 1'b0;
  endtask

  task automatic look(input logic [4:0] r);
    lk_reg_i = r;
    #1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(20 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [3:0] t;
    int base;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    #1;

    // R1 reset state
    check("R1 ready", alloc_ready_o, 1);
    check("R1 tag", alloc_tag_o, 0);
    check("R1 ret_valid", ret_valid_o, 0);
    check("R1 ret_exc", ret_exc_o, 0);
    look(5'd3);
    check("R1 lk_hit", lk_hit_o, 0);

    // R2 allocate five: dst 3,5,3,7,3
    do_alloc(5'd3, 1'b0, t); check("R2 tag0", t, 0);
    do_alloc(5'd5, 1'b0, t); check("R2 tag1", t, 1);
    do_alloc(5'd3, 1'b0, t); check("R2 tag2", t, 2);
    do_alloc(5'd7, 1'b0, t); check("R2 tag3", t, 3);
    do_alloc(5'd3, 1'b0, t); check("R2 tag4", t, 4);
    look(5'd3);
    check("R2 new slot pending", lk_ready_o, 0);

    // R4 R7 R8 R9 vector walk
    for (int i = 0; i < NROW; i++) begin
      if (VEC[i][79]) do_wb(VEC[i][78:75], VEC[i][74:43], 1'b0);
      look(VEC[i][42:38]);
      check($sformatf("R7/R8/R9 row%0d hit", i), lk_hit_o, VEC[i][37]);
      check($sformatf("R4/R7/R8 row%0d ready", i), lk_ready_o, VEC[i][36]);
      if (VEC[i][37]) check($sformatf("R7/R8 row%0d tag", i), lk_tag_o, VEC[i][35:32]);
      if (VEC[i][36]) check($sformatf("R4/R7 row%0d data", i), lk_data_o, VEC[i][31:0]);
    end
    check("R5 nothing retired yet", n_log, 0);

    // R5 in-order drain
    do_wb(4'd3, 32'h0000_00D3, 1'b0);
    check("R5 head not done", n_log, 0);
    do_wb(4'd0, 32'h0000_00E0, 1'b0);
    repeat (8) tick();
    check("R5 count", n_log, 5);
    check("R5 r0", {log_reg[0], log_data[0]}, {5'd3, 32'h00E0});
    check("R5 r1", {log_reg[1], log_data[1]}, {5'd5, 32'h00B1});
    check("R5 r2", {log_reg[2], log_data[2]}, {5'd3, 32'h00A2});
    check("R5 r3", {log_reg[3], log_data[3]}, {5'd7, 32'h00D3});
    check("R5 r4", {log_reg[4], log_data[4]}, {5'd3, 32'h00C4});
    check("R5 one per cycle", log_cyc[4] - log_cyc[0], 4);
    look(5'd3);
    check("R5 retired gone", lk_hit_o, 0);

    // R6 faulting instruction
    do_alloc(5'd10, 1'b0, t); check("R2 tag5", t, 5);
    do_wb(4'd5, 32'h55, 1'b1);
    repeat (3) tick();
    check("R6 exc pulse once", n_exc, 1);
    check("R6 write suppressed", n_log, 5);
    look(5'd10);
    check("R6 slot removed", lk_hit_o, 0);

    // R10 R11 R12 flush
    do_alloc(5'd1, 1'b1, t); check("R2 tag6", t, 6);
    do_alloc(5'd2, 1'b0, t);
    do_alloc(5'd2, 1'b0, t);
    do_flush(4'd7);
    check("R11 non-branch ignored", alloc_tag_o, 9);
    look(5'd2);
    check("R11 slots kept", {lk_hit_o, lk_tag_o}, {1'b1, 4'd8});
    do_flush(4'd12);
    check("R11 free slot ignored", alloc_tag_o, 9);
    do_flush(4'd6);
    check("R10 tail reset", alloc_tag_o, 7);
    look(5'd2);
    check("R10 younger discarded", lk_hit_o, 0);
    look(5'd1);
    check("R10 branch kept", {lk_hit_o, lk_ready_o, lk_tag_o}, {1'b1, 1'b0, 4'd6});
    do_wb(4'd8, 32'h99, 1'b0);
    do_alloc(5'd2, 1'b0, t); check("R10 realloc tag7", t, 7);
    do_alloc(5'd2, 1'b0, t); check("R10 realloc tag8", t, 8);
    look(5'd2);
    check("R12 stale wb ignored", {lk_hit_o, lk_ready_o, lk_tag_o}, {1'b1, 1'b0, 4'd8});
    do_wb(4'd6, 32'h61, 1'b0);
    do_wb(4'd7, 32'h71, 1'b0);
    do_wb(4'd8, 32'h81, 1'b0);
    repeat (4) tick();
    check("R5 post-flush count", n_log, 8);
    check("R5 post-flush r5", {log_reg[5], log_data[5]}, {5'd1, 32'h61});
    check("R5 post-flush r6", {log_reg[6], log_data[6]}, {5'd2, 32'h71});
    check("R5 post-flush r7", {log_reg[7], log_data[7]}, {5'd2, 32'h81});

    // R3 full, with wrap
    base = 0;
    for (int i = 0; i < 16; i++) begin
      do_alloc(5'd20, 1'b0, t);
      if (t == 4'(9 + i)) base++;
    end
    check("R2 wrap tags", base, 16);
    check("R3 not ready", alloc_ready_o, 0);
    check("R3 tag at head", alloc_tag_o, 9);
    alloc_valid_i = 1'b1; alloc_dst_i = 5'd21;
    tick();
    alloc_valid_i = 1'b0;
    check("R3 dropped tag", alloc_tag_o, 9);
    look(5'd21);
    check("R3 dropped slot", lk_hit_o, 0);
    look(5'd20);
    check("R7 wrap youngest", {lk_hit_o, lk_ready_o, lk_tag_o}, {1'b1, 1'b0, 4'd8});
    do_wb(4'd9, 32'h90, 1'b0);
    tick();
    check("R3 ready after retire", alloc_ready_o, 1);
    check("R3 tag after retire", alloc_tag_o, 9);
    check("R5 head retired", n_log, 9);

    summary();
    $finish;
  end
endmodule